// File: doc/BRIEF.md
# Grouped Compare Shadow-Register Loader

This block keeps double-buffered compare values for a seven-channel timer. Each channel has a compare register that software writes and a shadow latch that the comparators read. A write lands in the compare register at once. The shadow latch takes the new value either right away or later, when the load event selected for that channel occurs. The counter, the counting mode and the counting direction come from outside the block.

Channels 1–2, 3–4 and 5–6 can be grouped into pairs. In a pair, the lower channel's load mode decides when the pair loads, and both shadow latches update on the same clock edge.

Each channel is controlled by a two-state machine. `ST_IDLE` means no write is waiting. `ST_ARMED` means a written value is waiting for its load event. The transitions are:
- `ARM`: a write while the effective mode is not immediate, which also covers a write while already armed.
- `FIRE`: the load strobe with no new deferred write, going from ARMED to IDLE.
- `FLUSH`: an immediate-mode write while armed, going from ARMED to IDLE.

Top module: `cmp_shadow_loader`

## Requirements
- R1: A synchronous reset clears every compare register, every shadow latch and every pending write. All `shadow_q` fields read 0 after reset.
- R2: With load mode 0 (immediate), a write to channel n appears on shadow field n after the clock edge that accepts the write.
- R3: With load mode 1, a written value stays hidden until a cycle in which `cnt_val` is 0. The latch updates on the edge that ends that cycle.
- R4: With load mode 2 and counter mode 1 or 2 (up to period, continuous), only a counter value of 0 loads. A counter equal to channel 0's latch does not load.
- R5: With load mode 2 and counter mode 3 (up/down), a load occurs when the counter is 0, or when it equals channel 0's latch while counting up (`cnt_dn`=0). The latch match does not load while counting down.
- R6: With load mode 3, a load occurs when the counter equals the channel's own current latch value.
- R7: A load happens only for a write accepted on an earlier edge. A write in a cycle that already meets the event waits for the next event. With no pending write, the latch holds.
- R8: With `grp_en`=1, the members of a pair load on the same edge. The condition is the lower channel's mode, and the upper channel's own mode field is ignored.
- R9: With `grp_en`=1 and the lower channel in mode 0, each member loads immediately on its own write.
- R10: With `grp_en`=0, the channels of a pair load independently, each under its own mode.
- R11: With `grp_en`=1 and the lower channel in mode 3, the pair loads when the counter equals the lower channel's latch.

Load-mode codes: 0 immediate, 1 zero, 2 zero-or-period, 3 own latch. Channel n's mode field is `ld_mode[2n+1:2n]`. Its shadow field is `shadow_q[16n+15:16n]`. Counter-mode codes: 0 stop, 1 up, 2 continuous, 3 up/down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_val | input | 16 | Counter value for this cycle |
| cnt_mode | input | 2 | Counter mode code |
| cnt_dn | input | 1 | 1 while the counter counts down |
| ld_mode | input | 14 | Per-channel load-mode fields, 2 bits each |
| grp_en | input | 1 | Pair channels 1–2, 3–4, 5–6 |
| wr_en | input | 1 | Compare register write strobe |
| wr_sel | input | 3 | Channel written |
| wr_data | input | 16 | Write data |
| shadow_q | output | 112 | Shadow latches, 16 bits per channel |

## Verification
An immediate write shows on the shadow output after the same edge that stores the compare register. A deferred load shows after the edge that ends the cycle in which the counter met the condition. The earliest cycle in which any change can be seen is therefore one edge after the stimulus. The bench applies inputs, lets exactly one rising edge pass, and compares all seven fields at the falling edge that follows. It compares them against a behavioural model that was advanced from the same inputs. It also adds targeted checks on the values that each scenario makes due at that edge.

// File: rtl/cmp_shadow_pkg.sv
package cmp_shadow_pkg;

    typedef enum logic [1:0] {
        LD_IMM      = 2'd0,
        LD_ZERO     = 2'd1,
        LD_ZERO_PRD = 2'd2,
        LD_SELF     = 2'd3
    } ld_mode_e;

    typedef enum logic [1:0] {
        CM_STOP = 2'd0,
        CM_UP   = 2'd1,
        CM_CONT = 2'd2,
        CM_UPDN = 2'd3
    } cnt_mode_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } chan_st_e;

endpackage

// File: rtl/cmp_load_event.sv
module cmp_load_event
    import cmp_shadow_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    cnt_mode,
    input  logic          cnt_dn,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] per_val,
    input  logic [CW-1:0] ref_val,
    output logic          evt
);

    logic at_zero;
    logic at_top;

    assign at_zero = (cnt == '0);
    assign at_top  = (cnt_mode_e'(cnt_mode) == CM_UPDN) && !cnt_dn && (cnt == per_val);

    always_comb begin
        unique case (ld_mode_e'(mode))
            LD_IMM:      evt = 1'b0;
            LD_ZERO:     evt = at_zero;
            LD_ZERO_PRD: evt = at_zero || at_top;
            LD_SELF:     evt = (cnt == ref_val);
        endcase
    end

endmodule

// File: rtl/cmp_group_ctrl.sv
module cmp_group_ctrl #(
    parameter int NCH = 7,
    parameter int CW  = 16
) (
    input  logic              grp_en,
    input  logic [2*NCH-1:0]  ld_mode,
    input  logic [NCH*CW-1:0] lat,
    input  logic [NCH-1:0]    armed,
    output logic [2*NCH-1:0]  eff_mode,
    output logic [NCH*CW-1:0] ref_val,
    output logic [NCH-1:0]    grp_armed
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam int LEAD = (i > 0 && (i % 2) == 0) ? i - 1 : i;
        localparam int MATE = (i == 0) ? i :
                              ((i % 2) == 1) ? ((i + 1 < NCH) ? i + 1 : i) : i - 1;

        assign eff_mode[2*i +: 2] = grp_en ? ld_mode[2*LEAD +: 2] : ld_mode[2*i +: 2];
        assign ref_val[CW*i +: CW] = grp_en ? lat[CW*LEAD +: CW] : lat[CW*i +: CW];
        assign grp_armed[i]        = grp_en ? (armed[i] | armed[MATE]) : armed[i];
    end

endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmp_shadow_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          imm,
    input  logic          load,
    output logic [CW-1:0] latch,
    output logic          armed
);

    chan_st_e      state, nxt;
    logic [CW-1:0] ccr;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Transitions: ARM, FIRE, FLUSH
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (wr && !imm) nxt = ST_ARMED;
            ST_ARMED: begin
                if (wr && !imm)     nxt = ST_ARMED;
                else if (wr && imm) nxt = ST_IDLE;
                else if (load)      nxt = ST_IDLE;
            end
        endcase
    end

    // Data path driven by the same events
    always_ff @(posedge clk) begin
        if (rst) begin
            ccr   <= '0;
            latch <= '0;
        end else begin
            if (wr)        ccr   <= wdata;
            if (wr && imm) latch <= wdata;
            else if (load) latch <= ccr;
        end
    end

    assign armed = (state == ST_ARMED);

    p_imm_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && imm) |=> (latch == $past(wdata)));

    p_deferred_copy_r3: assert property (@(posedge clk) disable iff (rst)
        (load && !(wr && imm)) |=> (latch == $past(ccr)));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && !(wr && imm)) |=> $stable(latch));

endmodule

// File: rtl/cmp_shadow_loader.sv
module cmp_shadow_loader
    import cmp_shadow_pkg::*;
#(
    parameter int NCH = 7,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cnt_val,
    input  logic [1:0]        cnt_mode,
    input  logic              cnt_dn,
    input  logic [2*NCH-1:0]  ld_mode,
    input  logic              grp_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [CW-1:0]     wr_data,
    output logic [NCH*CW-1:0] shadow_q
);

    logic [NCH-1:0]    armed;
    logic [NCH-1:0]    grp_armed;
    logic [NCH-1:0]    evt;
    logic [NCH-1:0]    load_v;
    logic [2*NCH-1:0]  eff_mode;
    logic [NCH*CW-1:0] ref_val;

    cmp_group_ctrl #(.NCH(NCH), .CW(CW)) u_grp (
        .grp_en    (grp_en),
        .ld_mode   (ld_mode),
        .lat       (shadow_q),
        .armed     (armed),
        .eff_mode  (eff_mode),
        .ref_val   (ref_val),
        .grp_armed (grp_armed)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic wr_i;
        assign wr_i = wr_en && (wr_sel == 3'(i));

        cmp_load_event #(.CW(CW)) u_evt (
            .cnt      (cnt_val),
            .cnt_mode (cnt_mode),
            .cnt_dn   (cnt_dn),
            .mode     (eff_mode[2*i +: 2]),
            .per_val  (shadow_q[CW-1:0]),
            .ref_val  (ref_val[CW*i +: CW]),
            .evt      (evt[i])
        );

        assign load_v[i] = evt[i] && grp_armed[i];

        cmp_channel #(.CW(CW)) u_ch (
            .clk   (clk),
            .rst   (rst),
            .wr    (wr_i),
            .wdata (wr_data),
            .imm   (eff_mode[2*i +: 2] == 2'd0),
            .load  (load_v[i]),
            .latch (shadow_q[CW*i +: CW]),
            .armed (armed[i])
        );
    end

    p_pair_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (grp_en && load_v[1] && !wr_en) |=> (armed[2:1] == 2'b00));

    p_no_idle_load_r7: assert property (@(posedge clk) disable iff (rst)
        (!grp_en && !armed[0]) |-> !load_v[0]);

endmodule

// File: tb/cmp_shadow_loader_bench.sv
module cmp_shadow_loader_bench;

    localparam int NCH = 7;
    localparam int CW  = 16;

    logic              clk = 0;
    logic              rst;
    logic [CW-1:0]     cnt_val;
    logic [1:0]        cnt_mode;
    logic              cnt_dn;
    logic [2*NCH-1:0]  ld_mode;
    logic              grp_en;
    logic              wr_en;
    logic [2:0]        wr_sel;
    logic [CW-1:0]     wr_data;
    logic [NCH*CW-1:0] shadow_q;

    always #5 clk = ~clk;

    cmp_shadow_loader #(.NCH(NCH), .CW(CW)) u_cmp_shadow_loader (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_mode(cnt_mode),
        .cnt_dn(cnt_dn), .ld_mode(ld_mode), .grp_en(grp_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .shadow_q(shadow_q)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string tag    = "R1";
    int    m_ccr[NCH];
    int    m_lat[NCH];
    bit    m_pend[NCH];

    function automatic int got(int ch);
        return int'(shadow_q[CW*ch +: CW]);
    endfunction

    task automatic chk(string req, int ch, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s ch%0d actual=%h expected=%h", req, ch, act, exp);
        end
    endtask

    // One clock: advance the model from the inputs, pass an edge, compare
    task automatic tick();
        int nccr[NCH]; int nlat[NCH]; bit npend[NCH];
        for (int i = 0; i < NCH; i++) begin
            int lead = (grp_en && i > 0 && i % 2 == 0) ? i - 1 : i;
            int mate = (i == 0) ? 0 : (i % 2 == 1 ? i + 1 : i - 1);
            int m    = int'(ld_mode[2*lead +: 2]);
            bit ev, arm, ld, w;
            case (m)
                1: ev = (cnt_val == 0);
                2: ev = (cnt_val == 0) ||
                        (cnt_mode == 3 && !cnt_dn && int'(cnt_val) == m_lat[0]);
                3: ev = (int'(cnt_val) == m_lat[lead]);
                default: ev = 0;
            endcase
            arm = (grp_en && i > 0) ? (m_pend[i] || m_pend[mate]) : m_pend[i];
            ld  = ev && arm;
            w   = wr_en && int'(wr_sel) == i;
            nccr[i]  = w ? int'(wr_data) : m_ccr[i];
            nlat[i]  = (w && m == 0) ? int'(wr_data) : (ld ? m_ccr[i] : m_lat[i]);
            npend[i] = w ? (m != 0) : (ld ? 1'b0 : m_pend[i]);
        end
        @(posedge clk);
        m_ccr = nccr; m_lat = nlat; m_pend = npend;
        @(negedge clk);
        for (int i = 0; i < NCH; i++) chk(tag, i, got(i), m_lat[i]);
    endtask

    task automatic wr(int ch, int d);
        wr_en = 1; wr_sel = 3'(ch); wr_data = CW'(d);
        tick();
        wr_en = 0;
    endtask

    task automatic set_mode(int ch, int m);
        ld_mode[2*ch +: 2] = 2'(m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; cnt_val = 16'h0005; cnt_mode = 2; cnt_dn = 0; ld_mode = '0;
        grp_en = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        for (int i = 0; i < NCH; i++) begin m_ccr[i] = 0; m_lat[i] = 0; m_pend[i] = 0; end
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int i = 0; i < NCH; i++) chk("R1", i, got(i), 0);

        // R2 immediate writes to every channel
        tag = "R2";
        for (int i = 0; i < NCH; i++) begin
            wr(i, 16'h0100 + 16'h0011 * i);
            chk("R2", i, got(i), 16'h0100 + 16'h0011 * i);
        end

        // R3 zero-event load
        tag = "R3";
        set_mode(1, 1);
        wr(1, 16'h1111);
        chk("R3", 1, got(1), 16'h0111);
        tick(); tick();
        chk("R3", 1, got(1), 16'h0111);
        cnt_val = 0; tick(); cnt_val = 5;
        chk("R3", 1, got(1), 16'h1111);

        // R4 zero-or-period in continuous mode: period match ignored
        tag = "R4";
        set_mode(2, 2); cnt_mode = 2;
        wr(2, 16'h2222);
        cnt_val = 16'h0100; tick();
        chk("R4", 2, got(2), 16'h0122);
        cnt_val = 0; tick(); cnt_val = 5;
        chk("R4", 2, got(2), 16'h2222);

        // R5 up/down: period match counting up loads, counting down does not
        tag = "R5";
        cnt_mode = 3;
        wr(2, 16'h2A2A);
        cnt_val = 16'h0100; cnt_dn = 1; tick();
        chk("R5", 2, got(2), 16'h2222);
        cnt_dn = 0; tick();
        chk("R5", 2, got(2), 16'h2A2A);
        cnt_val = 5; cnt_mode = 2;

        // R6 own-latch match
        tag = "R6";
        set_mode(3, 3);
        wr(3, 16'h3333);
        cnt_val = 16'h0134; tick();
        chk("R6", 3, got(3), 16'h0133);
        cnt_val = 16'h0133; tick(); cnt_val = 5;
        chk("R6", 3, got(3), 16'h3333);

        // R7 write during an event cycle waits for the next event
        tag = "R7";
        cnt_val = 0;
        wr(1, 16'h1717);
        chk("R7", 1, got(1), 16'h1111);
        tick();
        chk("R7", 1, got(1), 16'h1717);
        tick();
        chk("R7", 1, got(1), 16'h1717);
        cnt_val = 5;

        // R8 grouped pair follows lower channel's mode (1), upper's mode 3 ignored
        tag = "R8";
        grp_en = 1; set_mode(1, 1); set_mode(2, 3);
        wr(1, 16'h1818); wr(2, 16'h2828);
        cnt_val = 16'h2A2A; tick();
        chk("R8", 2, got(2), 16'h2A2A);
        cnt_val = 0; tick(); cnt_val = 5;
        chk("R8", 1, got(1), 16'h1818);
        chk("R8", 2, got(2), 16'h2828);

        // R9 grouped immediate
        tag = "R9";
        set_mode(3, 0); set_mode(4, 1);
        wr(4, 16'h4949);
        chk("R9", 4, got(4), 16'h4949);
        wr(3, 16'h3939);
        chk("R9", 3, got(3), 16'h3939);

        // R10 ungrouped pair independent
        tag = "R10";
        grp_en = 0; set_mode(5, 1); set_mode(6, 0);
        wr(5, 16'h5A5A); wr(6, 16'h6A6A);
        chk("R10", 6, got(6), 16'h6A6A);
        chk("R10", 5, got(5), 16'h0155);
        cnt_val = 0; tick(); cnt_val = 5;
        chk("R10", 5, got(5), 16'h5A5A);

        // R11 grouped own-latch match on the lower channel's latch
        tag = "R11";
        grp_en = 1; set_mode(5, 3); set_mode(6, 1);
        wr(5, 16'h5B5B); wr(6, 16'h6B6B);
        cnt_val = 0; tick();
        chk("R11", 6, got(6), 16'h6A6A);
        cnt_val = 16'h5A5A; tick(); cnt_val = 5;
        chk("R11", 5, got(5), 16'h5B5B);
        chk("R11", 6, got(6), 16'h6B6B);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule